// File: doc/BRIEF.md
# Trace Stream Target-Address Decoder

This block sits next to a processor's debug trace port and watches two 4-bit inputs on every clock: a status code and a nibble-wide data port. A status code announces a taken branch, and a later marker code tells how many bytes follow on the data port. From these the block rebuilds the branch target address and hands it to an external tracker. The tracker combines the address with a program image to follow execution across changes of flow that a program image cannot resolve by itself.

Besides the address, the block turns the long-lived processor states into level outputs: exception processing, debug-mode entry, stopped and halted. It flags reserved status codes. If a long-lived state cuts into a byte transfer, the block drops the partial capture and signals an abort. If a marker arrives without a preceding branch code, the bytes are still captured but are tagged as plain data rather than a branch target.

Top module: `trace_tgt_decoder`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, addr_o, byte_cnt_o, addr_valid_o, is_branch_o, abort_o, rsv_err_o and all four held-state outputs read zero.
- R2: Status codes 8, 9, 4'hA and 4'hB (binary 10xx) are markers announcing N = xx+1 bytes. On the 2N cycles that follow the marker cycle, ddata_i is taken one nibble per cycle, and the k-th nibble (k from 0) lands in addr_o bits [4k+3:4k], least significant first.
- R3: Address bytes that were not transmitted read as zero in addr_o, even when a previous capture left non-zero bits there.
- R4: addr_valid_o is high for exactly one cycle, the cycle after the last nibble was sampled, and at that time byte_cnt_o holds N (1 to 4). addr_o, byte_cnt_o and is_branch_o keep their values until the next completed capture.
- R5: is_branch_o is 1 for a capture whose marker came after a status 5 with only code 0 seen between them. Otherwise it is 0.
- R6: Status 4'hC, 4'hD, 4'hE and 4'hF drive held_exc_o, held_dbg_o, held_stop_o and held_halt_o respectively. Each is high from the cycle after the code is first sampled until the cycle after it is no longer present, with no pulsing while the code persists.
- R7: Each cycle in which status 2 or 6 is sampled raises rsv_err_o for one cycle in the following cycle.
- R8: A status code in 4'hC..4'hF sampled while a capture is in progress discards the capture. abort_o pulses for one cycle in the next cycle, addr_valid_o stays low, and addr_o keeps its previous value.
- R9: During a capture, status codes outside 4'hC..4'hF (including further markers) neither restart nor shorten it, and nibble collection continues.
- R10: A marker sampled in the cycle right after the last nibble of a capture starts a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| status_i | input | 4 | Processor status code |
| ddata_i | input | 4 | Debug data nibble |
| addr_o | output | 32 | Assembled target address |
| addr_valid_o | output | 1 | One-cycle strobe on capture completion |
| byte_cnt_o | output | 3 | Number of bytes in the last capture |
| is_branch_o | output | 1 | Last capture followed a taken-branch code |
| abort_o | output | 1 | One-cycle pulse when a capture is discarded |
| rsv_err_o | output | 1 | One-cycle pulse per reserved code sampled |
| held_exc_o | output | 1 | Exception-processing level |
| held_dbg_o | output | 1 | Debug-mode-entry level |
| held_stop_o | output | 1 | Stopped level |
| held_halt_o | output | 1 | Halted level |

## Verification
Every output is registered once behind the sampled inputs. Held levels, reserved-code errors and aborts therefore appear in the cycle after the status code that causes them. The address strobe appears in the cycle after the last nibble, which is 2N+1 cycles after the marker. The bench changes inputs on the falling edge and reads outputs at the next falling edge, so each read falls exactly one rising edge after the stimulus it checks. The intermediate nibble cycles are checked as well, to confirm that the strobe stays low there.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic       cont;
    logic       branch;
    logic       marker;
    logic [2:0] bytes;
    logic       rsv;
    logic       held;
    logic [3:0] held_vec;
  } stat_info_t;
endpackage

// File: rtl/trace_stat_decode.sv
module trace_stat_decode
  import trace_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  output stat_info_t        info_o
);
  always_comb begin
    info_o = '0;
    unique casez (status_i)
      4'b0000: info_o.cont = 1'b1;
      4'b0101: info_o.branch = 1'b1;
      4'b0010,
      4'b0110: info_o.rsv = 1'b1;
      4'b10??: begin
        info_o.marker = 1'b1;
        info_o.bytes  = {1'b0, status_i[1:0]} + 3'd1;
      end
      4'b11??: begin
        info_o.held = 1'b1;
        info_o.held_vec[status_i[1:0]] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trace_level_track.sv
module trace_level_track
  import trace_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stat_info_t info_i,
  output logic [3:0] held_o,
  output logic       rsv_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o    <= '0;
      rsv_err_o <= 1'b0;
    end else begin
      held_o    <= info_i.held_vec;
      rsv_err_o <= info_i.rsv;
    end
  end
endmodule

// File: rtl/trace_nib_collect.sv
module trace_nib_collect
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stat_info_t        info_i,
  input  logic [NIB_W-1:0]  ddata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic [2:0]        bytes_o,
  output logic              branch_o,
  output logic              abort_o
);
  localparam int MAX_NIB = ADDR_W / NIB_W;
  localparam int IDX_W   = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1;
  localparam int NPB     = 8 / NIB_W;

  logic              busy_q, pend_q, tag_q;
  logic [IDX_W-1:0]  idx_q, last_q, last_d;
  logic [2:0]        cnt_q;
  logic [ADDR_W-1:0] shreg_q, shreg_nx;

  // index of the final nibble for the announced byte count
  always_comb begin
    int total;
    total  = int'(info_i.bytes) * NPB;
    if (total > MAX_NIB) total = MAX_NIB;
    last_d = IDX_W'(total - 1);
  end

  always_comb begin
    shreg_nx = shreg_q;
    shreg_nx[idx_q*NIB_W +: NIB_W] = ddata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      tag_q    <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      addr_o   <= '0;
      valid_o  <= 1'b0;
      bytes_o  <= '0;
      branch_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      abort_o <= 1'b0;
      // branch code arms the tag; only "continue" keeps it
      if (info_i.branch)     pend_q <= 1'b1;
      else if (!info_i.cont) pend_q <= 1'b0;

      if (!busy_q) begin
        if (info_i.marker) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          last_q  <= last_d;
          shreg_q <= '0;
          tag_q   <= pend_q;
          cnt_q   <= info_i.bytes;
        end
      end else if (info_i.held) begin
        busy_q  <= 1'b0;
        abort_o <= 1'b1;
      end else begin
        shreg_q <= shreg_nx;
        if (idx_q == last_q) begin
          busy_q   <= 1'b0;
          addr_o   <= shreg_nx;
          valid_o  <= 1'b1;
          bytes_o  <= cnt_q;
          branch_o <= tag_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trace_tgt_decoder.sv
module trace_tgt_decoder
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        status_i,
  input  logic [NIB_W-1:0]  ddata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic [2:0]        byte_cnt_o,
  output logic              is_branch_o,
  output logic              abort_o,
  output logic              rsv_err_o,
  output logic              held_exc_o,
  output logic              held_dbg_o,
  output logic              held_stop_o,
  output logic              held_halt_o
);
  stat_info_t info;
  logic [3:0] held;

  trace_stat_decode u_dec (
    .status_i (status_i),
    .info_o   (info)
  );

  trace_level_track u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .info_i    (info),
    .held_o    (held),
    .rsv_err_o (rsv_err_o)
  );

  trace_nib_collect #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .info_i   (info),
    .ddata_i  (ddata_i),
    .addr_o   (addr_o),
    .valid_o  (addr_valid_o),
    .bytes_o  (byte_cnt_o),
    .branch_o (is_branch_o),
    .abort_o  (abort_o)
  );

  assign held_exc_o  = held[0];
  assign held_dbg_o  = held[1];
  assign held_stop_o = held[2];
  assign held_halt_o = held[3];
endmodule

// File: rtl/trace_tgt_decoder_chk.sv
module trace_tgt_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        status_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_valid_o,
  input logic [2:0]        byte_cnt_o,
  input logic              abort_o,
  input logic              rsv_err_o,
  input logic              held_exc_o,
  input logic              held_dbg_o,
  input logic              held_stop_o,
  input logic              held_halt_o
);
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (byte_cnt_o >= 3'd1 && byte_cnt_o <= 3'd4)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> $stable(addr_o)); // R4
  AST_RSV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 4'h2 || status_i == 4'h6) |=> rsv_err_o); // R7
  AST_HELD_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 4'hC) |=> held_exc_o); // R6
  AST_HELD_HALT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 4'hF) |=> !held_halt_o); // R6
  AST_HELD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({held_exc_o, held_dbg_o, held_stop_o, held_halt_o})); // R6
  AST_ABORT_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && addr_valid_o)); // R8
endmodule

bind trace_tgt_decoder trace_tgt_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .status_i     (status_i),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .byte_cnt_o   (byte_cnt_o),
  .abort_o      (abort_o),
  .rsv_err_o    (rsv_err_o),
  .held_exc_o   (held_exc_o),
  .held_dbg_o   (held_dbg_o),
  .held_stop_o  (held_stop_o),
  .held_halt_o  (held_halt_o)
);

// File: tb/tb_trace_tgt_decoder.sv
`timescale 1ns/1ps
module tb_trace_tgt_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  status = 4'h0;
  logic [3:0]  ddata = 4'h0;
  logic [31:0] addr;
  logic        valid, is_br, abort, rsv;
  logic [2:0]  cnt;
  logic        h_exc, h_dbg, h_stop, h_halt;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] last_addr = '0;

  always #2 clk = ~clk;

  trace_tgt_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status), .ddata_i(ddata),
    .addr_o(addr), .addr_valid_o(valid), .byte_cnt_o(cnt), .is_branch_o(is_br),
    .abort_o(abort), .rsv_err_o(rsv), .held_exc_o(h_exc), .held_dbg_o(h_dbg),
    .held_stop_o(h_stop), .held_halt_o(h_halt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle; returns at next falling edge with outputs settled
  task automatic cyc(logic [3:0] s, logic [3:0] d);
    status = s;
    ddata  = d;
    @(negedge clk);
  endtask

  // marker + nibbles; returns in the cycle after the last nibble
  task automatic send(int nb, logic [31:0] a, logic [3:0] mid_stat);
    cyc(4'h8 + 4'(nb - 1), 4'hF);
    for (int k = 0; k < 2 * nb; k++) begin
      cyc(mid_stat, a[4*k +: 4]);
      if (k < 2 * nb - 1) chk("R4 no early strobe", valid, 0);
    end
  endtask

  task automatic expect_done(string req, int nb, logic [31:0] a, logic br);
    logic [31:0] m;
    m = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
    chk({req, " valid"}, valid, 1);
    chk({req, " addr"}, addr, a & m);
    chk({req, " cnt"}, cnt, nb);
    chk({req, " branch"}, is_br, br);
    last_addr = a & m;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr, 0);
    chk("R1 flags", {valid, cnt, is_br, abort, rsv, h_exc, h_dbg, h_stop, h_halt}, 0);
    @(negedge clk); rst_ni = 1'b1;
    cyc(4'h0, 4'h0);
    chk("R1 after release", {addr, valid, cnt, is_br, abort, rsv, h_exc, h_dbg, h_stop, h_halt}, 0);
  endtask

  task automatic t_branch4;
    cyc(4'h5, 4'h0);
    send(4, 32'hDEAD_BEEF, 4'h0);
    expect_done("R2 4-byte", 4, 32'hDEAD_BEEF, 1);
    cyc(4'h0, 4'h0);
    chk("R4 strobe drop", valid, 0);
    chk("R4 addr hold", addr, 32'hDEAD_BEEF);
    chk("R4 cnt hold", cnt, 4);
  endtask

  task automatic t_short;
    // 1-byte after a 4-byte capture: upper bytes must clear (R3)
    cyc(4'h5, 4'h0); cyc(4'h0, 4'h0); cyc(4'h0, 4'h0);
    send(1, 32'hFFFF_FF3C, 4'h0);
    expect_done("R3 1-byte", 1, 32'h0000_003C, 1);
    cyc(4'h0, 4'h0);
    cyc(4'h5, 4'h0);
    send(3, 32'h0012_3456, 4'h0);
    expect_done("R2 3-byte", 3, 32'h0012_3456, 1);
    cyc(4'h0, 4'h0);
  endtask

  task automatic t_nonbranch;
    cyc(4'h5, 4'h0); cyc(4'h1, 4'h0);
    send(2, 32'h0000_A1B2, 4'h0);
    expect_done("R5 broken by code 1", 2, 32'h0000_A1B2, 0);
    cyc(4'h0, 4'h0);
    send(2, 32'h0000_7788, 4'h0);
    expect_done("R5 no branch code", 2, 32'h0000_7788, 0);
    cyc(4'h0, 4'h0);
  endtask

  task automatic t_held;
    cyc(4'hC, 4'h0);
    chk("R6 exc on", {h_exc, h_dbg, h_stop, h_halt}, 4'b1000);
    cyc(4'hC, 4'h0);
    chk("R6 exc persists", h_exc, 1);
    cyc(4'hD, 4'h0);
    chk("R6 dbg", {h_exc, h_dbg, h_stop, h_halt}, 4'b0100);
    cyc(4'hE, 4'h0);
    chk("R6 stop", {h_exc, h_dbg, h_stop, h_halt}, 4'b0010);
    cyc(4'hF, 4'h0); cyc(4'hF, 4'h0);
    chk("R6 halt", {h_exc, h_dbg, h_stop, h_halt}, 4'b0001);
    cyc(4'h0, 4'h0);
    chk("R6 released", {h_exc, h_dbg, h_stop, h_halt}, 4'b0000);
  endtask

  task automatic t_reserved;
    cyc(4'h2, 4'h0);
    chk("R7 code 2", rsv, 1);
    cyc(4'h6, 4'h0);
    chk("R7 code 6", rsv, 1);
    cyc(4'h0, 4'h0);
    chk("R7 clear", rsv, 0);
  endtask

  task automatic t_abort;
    cyc(4'h5, 4'h0);
    cyc(4'hB, 4'h0);
    cyc(4'h0, 4'h1); cyc(4'h0, 4'h2); cyc(4'h0, 4'h3);
    cyc(4'hE, 4'h4);
    chk("R8 abort pulse", abort, 1);
    chk("R8 no strobe", valid, 0);
    chk("R8 addr kept", addr, last_addr);
    cyc(4'h0, 4'h5);
    chk("R8 abort single", abort, 0);
    chk("R8 still no strobe", valid, 0);
    send(2, 32'h0000_CAFE, 4'h0);
    expect_done("R8 fresh capture", 2, 32'h0000_CAFE, 0);
    cyc(4'h0, 4'h0);
  endtask

  task automatic t_mid_codes;
    cyc(4'h5, 4'h0);
    send(2, 32'h0000_9ABC, 4'h8);
    expect_done("R9 markers ignored", 2, 32'h0000_9ABC, 1);
    cyc(4'h0, 4'h0);
    cyc(4'h9, 4'h0);
    cyc(4'h1, 4'h4); cyc(4'h5, 4'h3); cyc(4'h0, 4'h2); cyc(4'h1, 4'h1);
    expect_done("R9 mixed codes", 2, 32'h0000_1234, 0);
    cyc(4'h0, 4'h0);
  endtask

  task automatic t_back2back;
    cyc(4'h5, 4'h0);
    send(1, 32'h0000_0055, 4'h0);
    expect_done("R10 first", 1, 32'h0000_0055, 1);
    send(1, 32'h0000_00AA, 4'h0);
    expect_done("R10 second", 1, 32'h0000_00AA, 0);
    cyc(4'h0, 4'h0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_branch4();
        t_short();
        t_nonbranch();
        t_held();
        t_reserved();
        t_abort();
        t_mid_codes();
        t_back2back();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule